// File: doc/BRIEF.md
# Ternary Rule Matcher with Priority Select

This block classifies a 32-bit lookup key against a table of ternary rules. Each rule holds a literal pattern together with a per-bit don't-care mask. A rule matches when every bit that is not masked equals the corresponding key bit. The block compares every bit with an XNOR and then AND-reduces the results, so each rule produces one match bit. The full match vector is reported, along with a priority-selected winner. A higher rule index means a higher priority, so software must place rules in descending priority order, from slot RULE_N-1 down to slot 0.

A key is presented with a valid strobe. The match vector, the hit flag and the winning index are registered at the same clock edge and appear on the outputs one cycle later. There are no pipeline stages and no lookup tables. Rules are loaded one at a time through a slot-index, pattern and mask write port.

Top module: `tkc_top`

## Requirements
- R1: In reset, res_valid, res_hit, res_index and res_vector are all 0. Every rule slot resets to pattern 0 with no don't-care bits, so after reset key 0 matches every slot and any nonzero key matches none.
- R2: A write (wr_en=1 at a rising edge) stores wr_value and wr_dc into slot wr_idx. A key sampled at that same edge is still compared against the old contents of the slot. Keys sampled at later edges see the new contents.
- R3: Bit i of res_vector is 1 exactly when, at every bit position b, either dc[b] of rule i is 1 or key[b] equals the pattern bit b of rule i.
- R4: A wr_dc bit of 1 marks its position as don't-care. That position matches whatever the key bit and the stored pattern bit are. A rule with all 32 bits don't-care matches every key.
- R5: When any rule matches, res_hit is 1 and res_index is the highest set position of res_vector. Bit RULE_N-1 has the highest priority and bit 0 the lowest.
- R6: When no rule matches, res_hit is 0, res_index is 0 and res_vector is 0.
- R7: A key sampled with key_valid=1 at a rising edge updates res_vector, res_hit and res_index at that same edge. At that edge res_valid becomes 1. At an edge where key_valid=0, res_valid becomes 0.
- R8: While key_valid is 0, res_vector, res_hit and res_index hold their previous values, whatever the key input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Rule write strobe |
| wr_idx | input | 5 | Slot written; a higher slot has higher priority |
| wr_value | input | 32 | Rule pattern bits |
| wr_dc | input | 32 | Don't-care mask, 1 = position ignored |
| key_valid | input | 1 | Key is sampled at this edge |
| key | input | 32 | Lookup key |
| res_valid | output | 1 | Result registered from a valid key |
| res_vector | output | 32 | One match bit per rule |
| res_hit | output | 1 | At least one rule matched |
| res_index | output | 5 | Highest-priority matching slot, 0 on no hit |

## Verification
The assertions assume that key_valid and the write inputs are stable and free of unknowns around each rising edge. They also assume that wr_idx names an existing slot. The bench meets these assumptions by changing every input only on the falling edge and by using slot numbers 0 to 31 only. The sweeps flip every key bit against every stored rule. They step the priority winner down through all slots to the empty case, and they place a write and a lookup of the same slot on one edge.

// File: rtl/tkc_pkg.sv
package tkc_pkg;
  localparam int unsigned KEY_W_DEF  = 32;
  localparam int unsigned RULE_N_DEF = 32;

  // One stored ternary entry: pattern plus don't-care mask
  typedef struct packed {
    logic [KEY_W_DEF-1:0] value;
    logic [KEY_W_DEF-1:0] dc;
  } tkc_rule_t;
endpackage

// File: rtl/tkc_rule_store.sv
module tkc_rule_store #(
  parameter int unsigned KEY_W  = tkc_pkg::KEY_W_DEF,
  parameter int unsigned RULE_N = tkc_pkg::RULE_N_DEF,
  localparam int unsigned IDX_W = (RULE_N > 1) ? $clog2(RULE_N) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [KEY_W-1:0]             wr_value,
  input  logic [KEY_W-1:0]             wr_dc,
  output logic [RULE_N-1:0][KEY_W-1:0] rule_value,
  output logic [RULE_N-1:0][KEY_W-1:0] rule_dc
);

  for (genvar g = 0; g < RULE_N; g++) begin : g_slot
    logic             slot_en;
    logic [KEY_W-1:0] value_d, value_q;
    logic [KEY_W-1:0] dc_d, dc_q;

    always_comb begin
      slot_en = wr_en && (wr_idx == IDX_W'(g));
      value_d = wr_value;
      dc_d    = wr_dc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        value_q <= '0;
        dc_q    <= '0;
      end else if (slot_en) begin
        value_q <= value_d;
        dc_q    <= dc_d;
      end
    end

    assign rule_value[g] = value_q;
    assign rule_dc[g]    = dc_q;
  end

  // Slot contents after a write equal what was presented
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rule_value[$past(wr_idx)] == $past(wr_value)) &&
              (rule_dc[$past(wr_idx)] == $past(wr_dc)));

endmodule

// File: rtl/tkc_match_array.sv
module tkc_match_array #(
  parameter int unsigned KEY_W  = tkc_pkg::KEY_W_DEF,
  parameter int unsigned RULE_N = tkc_pkg::RULE_N_DEF
) (
  input  logic [KEY_W-1:0]             key,
  input  logic [RULE_N-1:0][KEY_W-1:0] rule_value,
  input  logic [RULE_N-1:0][KEY_W-1:0] rule_dc,
  output logic [RULE_N-1:0]            match_vec
);

  for (genvar g = 0; g < RULE_N; g++) begin : g_rule
    logic [KEY_W-1:0] bit_eq;
    logic [KEY_W-1:0] bit_ok;
    always_comb begin
      bit_eq       = ~(key ^ rule_value[g]);   // XNOR per bit
      bit_ok       = bit_eq | rule_dc[g];      // masked positions forced true
      match_vec[g] = &bit_ok;
    end
  end

endmodule

// File: rtl/tkc_prio_enc.sv
module tkc_prio_enc #(
  parameter int unsigned RULE_N = tkc_pkg::RULE_N_DEF,
  localparam int unsigned IDX_W = (RULE_N > 1) ? $clog2(RULE_N) : 1
) (
  input  logic [RULE_N-1:0] req,
  output logic [RULE_N-1:0] grant,
  output logic [IDX_W-1:0]  idx,
  output logic              any
);

  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    // Ascending scan: the last set bit seen (highest index) wins
    for (int i = 0; i < RULE_N; i++) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        any      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tkc_top.sv
module tkc_top #(
  parameter int unsigned KEY_W  = tkc_pkg::KEY_W_DEF,
  parameter int unsigned RULE_N = tkc_pkg::RULE_N_DEF,
  localparam int unsigned IDX_W = (RULE_N > 1) ? $clog2(RULE_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [KEY_W-1:0]  wr_value,
  input  logic [KEY_W-1:0]  wr_dc,
  input  logic              key_valid,
  input  logic [KEY_W-1:0]  key,
  output logic              res_valid,
  output logic [RULE_N-1:0] res_vector,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_index
);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [RULE_N-1:0][KEY_W-1:0] rule_value, rule_dc;
  logic [RULE_N-1:0]            match_vec;
  logic [RULE_N-1:0]            grant;
  logic [IDX_W-1:0]             win_idx;
  logic                         win_any;

  tkc_rule_store #(.KEY_W(KEY_W), .RULE_N(RULE_N)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_value   (wr_value),
    .wr_dc      (wr_dc),
    .rule_value (rule_value),
    .rule_dc    (rule_dc)
  );

  tkc_match_array #(.KEY_W(KEY_W), .RULE_N(RULE_N)) u_match (
    .key        (key),
    .rule_value (rule_value),
    .rule_dc    (rule_dc),
    .match_vec  (match_vec)
  );

  tkc_prio_enc #(.RULE_N(RULE_N)) u_enc (
    .req   (match_vec),
    .grant (grant),
    .idx   (win_idx),
    .any   (win_any)
  );

  // Next-state for the result registers
  logic              valid_d, hit_d;
  logic [RULE_N-1:0] vec_d;
  logic [IDX_W-1:0]  idx_d;
  logic              res_en;

  always_comb begin
    res_en  = key_valid;
    valid_d = key_valid;
    vec_d   = match_vec;
    hit_d   = win_any;
    idx_d   = win_idx;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      res_valid <= 1'b0;
    end else begin
      res_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      res_vector <= '0;
      res_hit    <= 1'b0;
      res_index  <= '0;
    end else if (res_en) begin
      res_vector <= vec_d;
      res_hit    <= hit_d;
      res_index  <= idx_d;
    end
  end

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    key_valid |=> res_valid);
  assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !key_valid |=> !res_valid);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !key_valid |=> ($stable(res_vector) && $stable(res_hit) && $stable(res_index)));
  assert_winner_set_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    res_hit |-> res_vector[res_index]);
  assert_winner_top_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    res_hit |-> ((res_vector >> res_index) == RULE_N'(1)));
  assert_miss_index_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !res_hit |-> (res_index == '0 && res_vector == '0));
  assert_hit_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    res_hit |-> (res_vector != '0));
  assert_grant_single_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(grant) && ((grant & ~match_vec) == '0));

endmodule

// File: tb/tkc_top_test.sv
`timescale 1ns/1ps
module tkc_top_test;
  localparam int KW = 32;
  localparam int RN = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [4:0]    wr_idx;
  logic [KW-1:0] wr_value, wr_dc;
  logic          key_valid;
  logic [KW-1:0] key;
  logic          res_valid;
  logic [RN-1:0] res_vector;
  logic          res_hit;
  logic [4:0]    res_index;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [KW-1:0] m_val [RN];
  logic [KW-1:0] m_dc  [RN];

  // Values expected from the most recent lookup
  logic [RN-1:0] e_vec;
  logic          e_hit;
  logic [4:0]    e_idx;

  always #5 clk = ~clk;

  tkc_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_value(wr_value), .wr_dc(wr_dc), .key_valid(key_valid), .key(key),
    .res_valid(res_valid), .res_vector(res_vector), .res_hit(res_hit),
    .res_index(res_index)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected outputs worked out from R3/R5/R6 for a given key
  task automatic model(input logic [KW-1:0] k);
    e_vec = '0;
    e_hit = 1'b0;
    e_idx = '0;
    for (int i = 0; i < RN; i++) begin
      if (((k ^ m_val[i]) & ~m_dc[i]) == '0) e_vec[i] = 1'b1;
    end
    for (int i = RN - 1; i >= 0; i--) begin
      if (e_vec[i] && !e_hit) begin
        e_hit = 1'b1;
        e_idx = 5'(i);
      end
    end
  endtask

  task automatic write_rule(input int idx, input logic [KW-1:0] v, input logic [KW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_value = v; wr_dc = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_val[idx] = v;
    m_dc[idx]  = d;
  endtask

  task automatic check_outputs(input string req);
    check({req, " valid"},  64'(res_valid),  64'(1));
    check({req, " vector"}, 64'(res_vector), 64'(e_vec));
    check({req, " hit"},    64'(res_hit),    64'(e_hit));
    check({req, " index"},  64'(res_index),  64'(e_idx));
  endtask

  task automatic lookup(input logic [KW-1:0] k, input string req);
    @(negedge clk);
    key = k; key_valid = 1'b1;
    model(k);
    @(negedge clk);
    key_valid = 1'b0;
    check_outputs(req);
  endtask

  function automatic logic [KW-1:0] hval(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [KW-1:0] hdc(input int i);
    return (i % 4 == 0) ? 32'h0 : (32'h0000_000F << (i % 28)) | (32'h1 << ((i * 7) % 32));
  endfunction

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_value = '0; wr_dc = '0;
    key_valid = 1'b0; key = '0;
    for (int i = 0; i < RN; i++) begin
      m_val[i] = '0;
      m_dc[i]  = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset values of the result registers
    check("R1 valid",  64'(res_valid),  64'(0));
    check("R1 vector", 64'(res_vector), 64'(0));
    check("R1 hit",    64'(res_hit),    64'(0));
    check("R1 index",  64'(res_index),  64'(0));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: cleared rules match only key 0; R6: nonzero key misses
    lookup(32'h0, "R1");
    lookup(32'h0000_0001, "R6");

    // R2: write and lookup of the same slot on one edge see old contents
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd7; wr_value = 32'h1234_5678; wr_dc = '0;
    key = 32'h1234_5678; key_valid = 1'b1;
    model(32'h1234_5678);
    @(negedge clk);
    wr_en = 1'b0; key_valid = 1'b0;
    m_val[7] = 32'h1234_5678;
    check_outputs("R2 same-edge");
    lookup(32'h1234_5678, "R2 after");
    lookup(32'h0, "R2 others");

    // R8: with key_valid low the outputs hold while the key moves
    @(negedge clk);
    key = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R8 hold vector", 64'(res_vector), 64'(e_vec));
    check("R8 hold hit",    64'(res_hit),    64'(e_hit));
    check("R8 hold index",  64'(res_index),  64'(e_idx));
    check("R7 valid low",   64'(res_valid),  64'(0));

    // R3/R4: load varied patterns and masks, flip every key bit of every rule
    for (int i = 0; i < RN; i++) write_rule(i, hval(i), hdc(i));
    for (int i = 0; i < RN; i++) begin
      lookup(hval(i), "R3 exact");
      for (int b = 0; b < KW; b++) lookup(hval(i) ^ (32'h1 << b), "R3/R4 flip");
    end

    // R4: all-don't-care rule matches any key even with a nonzero pattern
    write_rule(3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    lookup(32'h0, "R4 full mask");
    lookup(32'hA5A5_A5A5, "R4 full mask");

    // R5/R6: all slots equal, then remove the winner one slot at a time
    for (int i = 0; i < RN; i++) write_rule(i, 32'hC0DE_0042, 32'h0);
    lookup(32'hC0DE_0042, "R5 all");
    for (int i = RN - 1; i >= 0; i--) begin
      write_rule(i, 32'h0BAD_F00D ^ 32'(i), 32'h0);
      lookup(32'hC0DE_0042, (i == 0) ? "R6 none left" : "R5 step");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule